// File: doc/BRIEF.md
# Configurable-Format Asynchronous Serial Transmitter

This block turns a parallel data word into one frame on an asynchronous serial line. The line idles high. A frame is a low start bit, then 5 to 8 data bits sent least significant bit first, then an optional parity slot, then a high stop period. Line-control inputs pick the word length, the parity mode and the stop length. They are captured together with the data word when the word is accepted.

Bit timing comes from an external sub-tick enable that pulses sixteen times per bit period. Counting in sixteenths lets the block emit a stop period of one and a half bits for 5-bit words. Words arrive on a valid/ready handshake, and a busy output reports a frame in flight. The transmitter accepts the next word during the stop period of the current frame, so frames can follow each other with no idle gap.

Top module: `sftx_top`

## Requirements
- R1: After reset `txd` is high, `busy` is low and `in_ready` is high.
- R2: A frame starts with `txd` low for 16 sub-ticks, followed by data bits of 16 sub-ticks each, least significant bit first. The count is set by `word_len` (00=5, 01=6, 10=7, 11=8 bits), and `in_data` bits above that count have no effect on the line.
- R3: With `par_en`=1, `par_kind`=00 selects even parity and 01 selects odd parity. The parity slot makes the number of ones across the used data bits plus the parity bit even (00) or odd (01).
- R4: With `par_en`=1, `par_kind`=10 always sends 1 in the parity slot and `par_kind`=11 always sends 0.
- R5: With `par_en`=0 no parity slot is sent; the stop period follows the last data bit directly.
- R6: With `stop_sel`=0 the stop period is high for 16 sub-ticks.
- R7: With `stop_sel`=1 and `word_len`=00 the stop period is high for 24 sub-ticks.
- R8: With `stop_sel`=1 and `word_len` of 01, 10 or 11 the stop period is high for 32 sub-ticks.
- R9: An 8-bit frame with forced-one parity and a 16-sub-tick stop gives the same line waveform as an 8-bit frame without parity and a 32-sub-tick stop.
- R10: `in_ready` is high when idle, and also during the stop period until a word is taken; it is low from the start bit to the end of the last data or parity slot. A word taken during the stop period starts its start bit right after that period, with no idle sub-tick.
- R11: `busy` is high from the cycle after a word is accepted until the stop period of the last frame ends. `txd` changes only on a clock edge where `sub_tick` is high or a word is accepted.
- R12: Data and line-control inputs are sampled only when a word is accepted. Changing them during the frame has no effect on that frame's waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sub_tick | input | 1 | Enable pulse, 16 per bit period |
| word_len | input | 2 | Data bits: 00=5, 01=6, 10=7, 11=8 |
| stop_sel | input | 1 | 0: one stop bit; 1: 1.5 (5-bit) or 2 stop bits |
| par_en | input | 1 | Parity slot enable |
| par_kind | input | 2 | 00 even, 01 odd, 10 forced one, 11 forced zero |
| in_valid | input | 1 | Data word offered |
| in_data | input | 8 | Data word |
| in_ready | output | 1 | Word can be accepted this cycle |
| txd | output | 1 | Serial line output |
| busy | output | 1 | Frame in flight |

## Verification
Each of the four word lengths is sent with data whose upper unused bits are set, so a wrong length or a leak of unused bits changes the waveform. Even and odd parity are tried with words whose used bits and full byte have different ones counts, which separates correct masking from parity over the whole byte. Forced parities are tried with all-zero and all-one data, so a generated parity cannot pass for a forced one. The stop lengths, a chain of three back-to-back frames in mixed formats, inputs changed in mid-frame, and the forced-one/two-stop equivalence show whether the sub-tick counts, the gap-free chaining and the capture at acceptance are right.

// File: rtl/sftx_pkg.sv
package sftx_pkg;
    localparam int WORD_W      = 8;
    localparam int MIN_W       = 5;
    localparam int SUB_PER_BIT = 16;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_PAR   = 3'd3,
        ST_STOP  = 3'd4
    } tx_state_e;

    typedef enum logic [1:0] {
        PAR_EVEN  = 2'b00,
        PAR_ODD   = 2'b01,
        PAR_MARK  = 2'b10,
        PAR_SPACE = 2'b11
    } par_kind_e;

    typedef struct packed {
        logic [1:0] len;
        logic       stop2;
        logic       par_en;
        logic [1:0] par_kind;
    } fmt_t;
endpackage

// File: rtl/sftx_parity.sv
module sftx_parity
    import sftx_pkg::*;
(
    input  logic [WORD_W-1:0] data_i,
    input  fmt_t              fmt_i,
    output logic              bit_o
);
    logic [WORD_W-1:0] used;
    logic              ones_odd;

    for (genvar g = 0; g < WORD_W; g++) begin : g_mask
        if (g < MIN_W) begin : g_always
            assign used[g] = 1'b1;
        end else begin : g_len
            assign used[g] = ({1'b0, fmt_i.len} > 3'(g - MIN_W));
        end
    end

    assign ones_odd = ^(data_i & used);

    always_comb begin
        case (par_kind_e'(fmt_i.par_kind))
            PAR_EVEN:  bit_o = ones_odd;
            PAR_ODD:   bit_o = ~ones_odd;
            PAR_MARK:  bit_o = 1'b1;
            default:   bit_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/sftx_stop_len.sv
module sftx_stop_len
    import sftx_pkg::*;
#(
    parameter int SUB    = SUB_PER_BIT,
    parameter int STOP_W = $clog2(2 * SUB + 1)
) (
    input  fmt_t              fmt_i,
    output logic [STOP_W-1:0] ticks_o
);
    localparam logic [STOP_W-1:0] ONE_BIT  = STOP_W'(SUB);
    localparam logic [STOP_W-1:0] ONE_HALF = STOP_W'(SUB + SUB / 2);
    localparam logic [STOP_W-1:0] TWO_BIT  = STOP_W'(2 * SUB);

    always_comb begin
        if (!fmt_i.stop2) begin
            ticks_o = ONE_BIT;
        end else if (fmt_i.len == 2'b00) begin
            ticks_o = ONE_HALF;
        end else begin
            ticks_o = TWO_BIT;
        end
    end
endmodule

// File: rtl/sftx_seq.sv
module sftx_seq
    import sftx_pkg::*;
#(
    parameter int SUB    = SUB_PER_BIT,
    parameter int SUB_W  = $clog2(SUB),
    parameter int STOP_W = $clog2(2 * SUB + 1),
    parameter int IDX_W  = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              valid_i,
    input  logic [WORD_W-1:0] data_i,
    input  fmt_t              fmt_i,
    input  logic              par_bit_i,
    input  logic [STOP_W-1:0] stop_ticks_i,
    output logic [WORD_W-1:0] cur_data_o,
    output fmt_t              cur_fmt_o,
    output logic              ready_o,
    output logic              busy_o,
    output logic              txd_o
);
    typedef struct packed {
        tx_state_e         st;
        logic [SUB_W-1:0]  sub;
        logic [IDX_W-1:0]  idx;
        logic [STOP_W-1:0] stop_left;
        logic [WORD_W-1:0] data;
        fmt_t              fmt;
        logic              pend;
        logic              txd;
    } regs_t;

    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(SUB - 1);

    regs_t            q, n;
    logic             ready_w;
    logic             accept;
    logic             sub_last;
    logic [IDX_W-1:0] idx_last;

    assign ready_w = (q.st == ST_IDLE) || (q.st == ST_STOP && !q.pend);

    always_comb begin
        n        = q;
        accept   = valid_i && ready_w;
        sub_last = (q.sub == SUB_LAST);
        idx_last = IDX_W'(MIN_W - 1) + IDX_W'(q.fmt.len);

        case (q.st)
            ST_IDLE: begin
                if (accept) begin
                    n.data = data_i;
                    n.fmt  = fmt_i;
                    n.pend = 1'b0;
                    n.sub  = '0;
                    n.st   = ST_START;
                end
            end
            ST_START: begin
                if (tick_i) begin
                    n.sub = q.sub + 1'b1;
                    if (sub_last) begin
                        n.st  = ST_DATA;
                        n.idx = '0;
                        n.sub = '0;
                    end
                end
            end
            ST_DATA: begin
                if (tick_i) begin
                    n.sub = q.sub + 1'b1;
                    if (sub_last) begin
                        n.sub = '0;
                        if (q.idx == idx_last) begin
                            if (q.fmt.par_en) begin
                                n.st = ST_PAR;
                            end else begin
                                n.st        = ST_STOP;
                                n.stop_left = stop_ticks_i;
                            end
                        end else begin
                            n.idx = q.idx + 1'b1;
                        end
                    end
                end
            end
            ST_PAR: begin
                if (tick_i) begin
                    n.sub = q.sub + 1'b1;
                    if (sub_last) begin
                        n.sub       = '0;
                        n.st        = ST_STOP;
                        n.stop_left = stop_ticks_i;
                    end
                end
            end
            ST_STOP: begin
                if (accept) begin
                    n.data = data_i;
                    n.fmt  = fmt_i;
                    n.pend = 1'b1;
                end
                if (tick_i) begin
                    if (q.stop_left == STOP_W'(1)) begin
                        n.sub = '0;
                        if (n.pend) begin
                            n.st   = ST_START;
                            n.pend = 1'b0;
                        end else begin
                            n.st = ST_IDLE;
                        end
                    end else begin
                        n.stop_left = q.stop_left - 1'b1;
                    end
                end
            end
            default: begin
                n.st = ST_IDLE;
            end
        endcase

        case (n.st)
            ST_START: n.txd = 1'b0;
            ST_DATA:  n.txd = n.data[n.idx];
            ST_PAR:   n.txd = par_bit_i;
            default:  n.txd = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st        <= ST_IDLE;
            q.sub       <= '0;
            q.idx       <= '0;
            q.stop_left <= '0;
            q.data      <= '0;
            q.fmt       <= '0;
            q.pend      <= 1'b0;
            q.txd       <= 1'b1;
        end else begin
            q <= n;
        end
    end

    assign cur_data_o = q.data;
    assign cur_fmt_o  = q.fmt;
    assign ready_o    = ready_w;
    assign busy_o     = (q.st != ST_IDLE);
    assign txd_o      = q.txd;
endmodule

// File: rtl/sftx_top.sv
module sftx_top
    import sftx_pkg::*;
#(
    parameter int SUB    = SUB_PER_BIT,
    parameter int STOP_W = $clog2(2 * SUB + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sub_tick,
    input  logic [1:0]        word_len,
    input  logic              stop_sel,
    input  logic              par_en,
    input  logic [1:0]        par_kind,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    output logic              in_ready,
    output logic              txd,
    output logic              busy
);
    fmt_t              fmt_in;
    fmt_t              cur_fmt;
    logic [WORD_W-1:0] cur_data;
    logic              par_bit;
    logic [STOP_W-1:0] stop_ticks;

    always_comb begin
        fmt_in.len      = word_len;
        fmt_in.stop2    = stop_sel;
        fmt_in.par_en   = par_en;
        fmt_in.par_kind = par_kind;
    end

    sftx_parity u_par (
        .data_i (cur_data),
        .fmt_i  (cur_fmt),
        .bit_o  (par_bit)
    );

    sftx_stop_len #(.SUB(SUB), .STOP_W(STOP_W)) u_stop (
        .fmt_i   (cur_fmt),
        .ticks_o (stop_ticks)
    );

    sftx_seq #(.SUB(SUB), .STOP_W(STOP_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (sub_tick),
        .valid_i      (in_valid),
        .data_i       (in_data),
        .fmt_i        (fmt_in),
        .par_bit_i    (par_bit),
        .stop_ticks_i (stop_ticks),
        .cur_data_o   (cur_data),
        .cur_fmt_o    (cur_fmt),
        .ready_o      (in_ready),
        .busy_o       (busy),
        .txd_o        (txd)
    );
endmodule

// File: rtl/sftx_checker.sv
module sftx_checker (
    input logic clk,
    input logic rst_n,
    input logic sub_tick,
    input logic in_valid,
    input logic in_ready,
    input logic txd,
    input logic busy
);
    // R1: the line rests high whenever no frame is in flight
    a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd);

    // R10: an idle transmitter always offers ready
    a_r10_ready_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> in_ready);

    // R2: a word taken from idle drives the start level next cycle
    a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !busy) |=> !txd);

    // R11: acceptance makes the block busy
    a_r11_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> busy);

    // R11: the line moves only on a sub-tick or an acceptance
    a_r11_txd_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(sub_tick) && !$past(in_valid && in_ready)) |-> $stable(txd));
endmodule

bind sftx_top sftx_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sub_tick (sub_tick),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .txd      (txd),
    .busy     (busy)
);

// File: tb/sftx_top_test.sv
`timescale 1ns/1ps
module sftx_top_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sub_tick = 1'b0;
    logic [1:0] word_len = 2'b11;
    logic       stop_sel = 1'b0;
    logic       par_en = 1'b0;
    logic [1:0] par_kind = 2'b00;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready, txd, busy;

    typedef struct {
        logic [7:0] d;
        logic [1:0] len;
        logic       stp;
        logic       pe;
        logic [1:0] pk;
    } frame_t;

    frame_t frs [4];
    bit     cap  [$];
    bit     expq [$];
    bit     seg_a [$];
    bit     cap_en = 1'b0;
    int     tdiv = 0;
    int     n_chk = 0;
    int     n_fail = 0;
    bit     done = 1'b0;

    sftx_top uut (
        .clk(clk), .rst_n(rst_n), .sub_tick(sub_tick), .word_len(word_len),
        .stop_sel(stop_sel), .par_en(par_en), .par_kind(par_kind),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .txd(txd), .busy(busy)
    );

    always #2 clk = ~clk;

    // one sub-tick every third cycle; each sample is the line level of one sub-tick
    always @(negedge clk) begin
        if (cap_en && sub_tick) cap.push_back(txd);
        tdiv = (tdiv == 2) ? 0 : tdiv + 1;
        sub_tick = (tdiv == 0);
    end

    task automatic chk(input string req, input int act, input int exp_v, input string what);
        n_chk++;
        if (act != exp_v) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp_v);
        end
    endtask

    task automatic push_n(input bit v, input int cnt);
        for (int k = 0; k < cnt; k++) expq.push_back(v);
    endtask

    task automatic add_frame(input frame_t f);
        int nb;
        int ones;
        bit pb;
        nb = 5 + int'(f.len);
        ones = 0;
        push_n(1'b0, 16);
        for (int b = 0; b < nb; b++) begin
            push_n(f.d[b], 16);
            if (f.d[b]) ones++;
        end
        if (f.pe) begin
            case (f.pk)
                2'b00:   pb = (ones % 2) == 1;
                2'b01:   pb = (ones % 2) == 0;
                2'b10:   pb = 1'b1;
                default: pb = 1'b0;
            endcase
            push_n(pb, 16);
        end
        if (!f.stp)            push_n(1'b1, 16);
        else if (f.len == 2'b00) push_n(1'b1, 24);
        else                   push_n(1'b1, 32);
    endtask

    function automatic int first_low();
        for (int i = 0; i < cap.size(); i++) if (cap[i] == 1'b0) return i;
        return -1;
    endfunction

    // sends n frames from frs[], back to back, and compares the line against expq
    task automatic run(input int n, input string req, input bit scramble);
        int s;
        int mism;
        int first_bad;
        cap.delete();
        expq.delete();
        for (int i = 0; i < n; i++) add_frame(frs[i]);
        cap_en = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = frs[i].d;
            word_len = frs[i].len;
            stop_sel = frs[i].stp;
            par_en   = frs[i].pe;
            par_kind = frs[i].pk;
            while (!in_ready) @(negedge clk);
            @(posedge clk);
            if (i == 0) begin
                @(negedge clk);
                chk("R11", busy, 1, "busy after accept");
                chk("R10", in_ready, 0, "ready during start bit");
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        if (scramble) begin
            in_data  = ~in_data;
            word_len = ~word_len;
            stop_sel = ~stop_sel;
            par_en   = ~par_en;
            par_kind = ~par_kind;
        end
        while (busy) @(negedge clk);
        repeat (40) @(negedge clk);
        cap_en = 1'b0;
        s = first_low();
        mism = 0;
        first_bad = -1;
        if (s < 0) begin
            mism = expq.size();
        end else begin
            for (int i = 0; i < expq.size(); i++) begin
                if (s + i >= cap.size() || cap[s + i] != expq[i]) begin
                    mism++;
                    if (first_bad < 0) first_bad = i;
                end
            end
            for (int i = s + expq.size(); i < cap.size(); i++)
                if (cap[i] != 1'b1) mism++;
        end
        chk(req, mism, 0, $sformatf("waveform mismatched sub-ticks (first at %0d)", first_bad));
        chk("R1", {in_ready, txd, busy}, 3'b110, "ready/txd/busy after frame");
    endtask

    function automatic frame_t mk(input logic [7:0] d, input logic [1:0] len,
                                  input logic stp, input logic pe, input logic [1:0] pk);
        frame_t f;
        f.d = d; f.len = len; f.stp = stp; f.pe = pe; f.pk = pk;
        return f;
    endfunction

    task automatic t_reset();
        chk("R1", txd, 1, "txd in reset");
        chk("R1", busy, 0, "busy in reset");
        chk("R1", in_ready, 1, "ready in reset");
    endtask

    task automatic t_lengths();
        // upper unused bits set to show they are ignored
        frs[0] = mk(8'hE6, 2'b00, 1'b0, 1'b0, 2'b00); run(1, "R2 R6 len5", 1'b0);
        frs[0] = mk(8'hC3, 2'b01, 1'b0, 1'b0, 2'b00); run(1, "R2 R5 len6", 1'b0);
        frs[0] = mk(8'hB5, 2'b10, 1'b0, 1'b0, 2'b00); run(1, "R2 len7", 1'b0);
        frs[0] = mk(8'h96, 2'b11, 1'b0, 1'b0, 2'b00); run(1, "R2 R6 len8", 1'b0);
    endtask

    task automatic t_parity();
        frs[0] = mk(8'h0B, 2'b11, 1'b0, 1'b1, 2'b00); run(1, "R3 even", 1'b0);
        frs[0] = mk(8'h0B, 2'b11, 1'b0, 1'b1, 2'b01); run(1, "R3 odd", 1'b0);
        frs[0] = mk(8'hF0, 2'b00, 1'b0, 1'b1, 2'b00); run(1, "R3 even masked", 1'b0);
    endtask

    task automatic t_forced();
        frs[0] = mk(8'h00, 2'b10, 1'b0, 1'b1, 2'b10); run(1, "R4 mark", 1'b0);
        frs[0] = mk(8'h7F, 2'b10, 1'b0, 1'b1, 2'b11); run(1, "R4 space", 1'b0);
    endtask

    task automatic t_stops();
        frs[0] = mk(8'h15, 2'b00, 1'b1, 1'b0, 2'b00); run(1, "R7 1.5 stop", 1'b0);
        frs[0] = mk(8'h2A, 2'b01, 1'b1, 1'b0, 2'b00); run(1, "R8 len6 2 stop", 1'b0);
        frs[0] = mk(8'hD2, 2'b11, 1'b1, 1'b1, 2'b01); run(1, "R8 len8 2 stop", 1'b0);
    endtask

    task automatic t_equiv();
        int s;
        int mism;
        frs[0] = mk(8'hA5, 2'b11, 1'b0, 1'b1, 2'b10);
        frs[1] = mk(8'h3C, 2'b11, 1'b0, 1'b1, 2'b10);
        run(2, "R9 mark-1stop", 1'b0);
        s = first_low();
        seg_a.delete();
        for (int i = 0; i < expq.size(); i++)
            seg_a.push_back((s >= 0 && s + i < cap.size()) ? cap[s + i] : 1'b0);
        frs[0] = mk(8'hA5, 2'b11, 1'b1, 1'b0, 2'b00);
        frs[1] = mk(8'h3C, 2'b11, 1'b1, 1'b0, 2'b00);
        run(2, "R9 none-2stop", 1'b0);
        s = first_low();
        mism = 0;
        for (int i = 0; i < seg_a.size(); i++)
            if (s < 0 || s + i >= cap.size() || cap[s + i] != seg_a[i]) mism++;
        chk("R9", mism, 0, "sub-ticks differing between the two formats");
        chk("R9", seg_a.size(), expq.size(), "frame pair length");
    endtask

    task automatic t_back_to_back();
        frs[0] = mk(8'h41, 2'b11, 1'b0, 1'b0, 2'b00);
        frs[1] = mk(8'h1C, 2'b00, 1'b1, 1'b1, 2'b00);
        frs[2] = mk(8'h62, 2'b10, 1'b1, 1'b1, 2'b10);
        run(3, "R10 back-to-back", 1'b0);
    endtask

    task automatic t_hold();
        frs[0] = mk(8'h5A, 2'b11, 1'b1, 1'b1, 2'b01);
        run(1, "R12 inputs changed mid-frame", 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_lengths();
        t_parity();
        t_forced();
        t_stops();
        t_equiv();
        t_back_to_back();
        t_hold();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule